// File: doc/BRIEF.md
# Snooping MESI Coherence Controller

This block keeps one private, direct-mapped cache coherent with its peers on a shared snooping bus under a write-invalidate policy. Every line carries one of four states: Invalid, Shared, Exclusive or Modified. The processor side issues single-word reads and writes and holds each request until the block signals completion. The block serves a request on its own when the line state allows it. Otherwise it asks for the bus and, once granted, issues a read, read-for-ownership, upgrade or writeback command. Each bus transaction takes a single cycle.

The snoop side sees the command and address of whichever other cache owns the bus in that cycle. It answers in the same cycle. It raises the share line when it holds a copy that is being read. When it holds the line dirty, it raises intervention and drives the line data, so that the requester and memory both take that value. It then downgrades or invalidates its own copy. A requester decides between Exclusive and Shared for a read fill from the share line it observes during its own read. A dirty victim is written back before the fill that replaces it.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read that hits a line in Shared, Exclusive or Modified completes with the stored data and drives no bus command.
- R2: A request that misses (line Invalid or tag different) completes only after its bus grant. A read issues command code 1 (read) and a write issues code 2 (read-for-ownership). Code 0 means no command.
- R3: A write that hits a Shared line issues command code 3 (upgrade) and leaves the line Modified.
- R4: A write that hits an Exclusive or Modified line completes with no bus command and leaves the line Modified.
- R5: A read fill enters Shared if the share input was high in the fill cycle and Exclusive if it was low. A later write to the line therefore needs an upgrade after a Shared fill and is silent after an Exclusive fill.
- R6: When a snooped read (code 1) hits a line held here, share_o is high in that cycle. For any other snooped command, or on a miss, share_o stays low.
- R7: When a snooped read hits a Modified line, intervention is raised with the line data in the same cycle. The requester fills with that data, memory captures it, and the line here becomes Shared.
- R8: A snooped read that hits an Exclusive line moves that line to Shared.
- R9: A snooped read-for-ownership (code 2) or upgrade (code 3) that hits a line held here moves it to Invalid. A read-for-ownership that hits a Modified line also raises intervention with its data.
- R10: A miss whose indexed line holds a different tag in Modified first issues command code 4 (writeback), carrying the victim address and data, and then issues the fill command. A clean victim is dropped without a writeback.
- R11: Across two caches, every read returns the last value written to its address, and at most one cache holds a given line in Exclusive or Modified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor request, held until cpu_done |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; low IDX_W bits select the line |
| cpu_wdata | input | DATA_W | Write data |
| cpu_done | output | 1 | Request completes at the coming clock edge |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_done on a read |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted this cycle |
| bus_cmd | output | 3 | Own bus command (0 none, 1 read, 2 read-for-ownership, 3 upgrade, 4 writeback) |
| bus_addr | output | ADDR_W | Address of own bus command |
| bus_wdata | output | DATA_W | Writeback data |
| bus_share_i | input | 1 | Wired share line seen during own command |
| bus_fill_data | input | DATA_W | Fill data returned for own read or read-for-ownership |
| snp_cmd | input | 3 | Command of the other bus owner this cycle |
| snp_addr | input | ADDR_W | Address of the snooped command |
| share_o | output | 1 | This cache holds the snooped line for a read |
| inter_o | output | 1 | This cache supplies the snooped line |
| inter_data | output | DATA_W | Data supplied with inter_o |

## Verification
The assertions assume a bus with a single owner per cycle: snp_cmd is nonzero only when bus_gnt is low. They also assume that cpu_req, cpu_we, cpu_addr and cpu_wdata stay stable from the cycle a request is raised until the cycle after cpu_done. The bench respects both through a one-winner arbiter that alternates between the two caches. It also runs one request at a time per cache and leaves an idle cycle after each completion. A behavioural model predicts every command sequence, share value, intervention value and read value. Directed cases cover each transition, and a pseudo-random mix of addresses that alias onto the same index forces many evictions.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
    typedef enum logic [2:0] {
        CMD_NONE = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDX  = 3'd2,
        CMD_UPG  = 3'd3,
        CMD_WB   = 3'd4
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LN_I = 2'd0,
        LN_S = 2'd1,
        LN_E = 2'd2,
        LN_M = 2'd3
    } line_st_e;

    typedef enum logic [1:0] {
        FSM_IDLE  = 2'd0,
        FSM_EVICT = 2'd1,
        FSM_FETCH = 2'd2
    } fsm_e;

    typedef struct packed {
        fsm_e fsm;
    } ctl_t;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int IDX_W  = 2,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  lk_idx,
    output line_st_e          lk_st,
    output logic [TAG_W-1:0]  lk_tag,
    output logic [DATA_W-1:0] lk_data,
    input  logic [IDX_W-1:0]  sn_idx,
    output line_st_e          sn_st,
    output logic [TAG_W-1:0]  sn_tag,
    output logic [DATA_W-1:0] sn_data,
    input  logic              wl_en,
    input  logic [IDX_W-1:0]  wl_idx,
    input  line_st_e          wl_st,
    input  logic [TAG_W-1:0]  wl_tag,
    input  logic              wl_data_en,
    input  logic [DATA_W-1:0] wl_data,
    input  logic              ws_en,
    input  logic [IDX_W-1:0]  ws_idx,
    input  line_st_e          ws_st,
    output line_st_e          st_all [1<<IDX_W]
);
    localparam int SETS = 1 << IDX_W;

    line_st_e          st_d   [SETS];
    line_st_e          st_q   [SETS];
    logic [TAG_W-1:0]  tag_d  [SETS];
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_d [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    assign lk_st   = st_q[lk_idx];
    assign lk_tag  = tag_q[lk_idx];
    assign lk_data = data_q[lk_idx];
    assign sn_st   = st_q[sn_idx];
    assign sn_tag  = tag_q[sn_idx];
    assign sn_data = data_q[sn_idx];

    always_comb begin
        for (int i = 0; i < SETS; i++) begin
            st_d[i]   = st_q[i];
            tag_d[i]  = tag_q[i];
            data_d[i] = data_q[i];
        end
        if (wl_en) begin
            st_d[wl_idx]  = wl_st;
            tag_d[wl_idx] = wl_tag;
            if (wl_data_en) data_d[wl_idx] = wl_data;
        end
        // a snoop update wins if both ever touch one line
        if (ws_en) st_d[ws_idx] = ws_st;
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < SETS; i++) begin
            if (!rst_n) begin
                st_q[i]   <= LN_I;
                tag_q[i]  <= '0;
                data_q[i] <= '0;
            end else begin
                st_q[i]   <= st_d[i];
                tag_q[i]  <= tag_d[i];
                data_q[i] <= data_d[i];
            end
        end
    end

    generate
        for (genvar g = 0; g < SETS; g++) begin : g_out
            assign st_all[g] = st_q[g];
        end
    endgenerate
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
    import mesi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 8
) (
    input  bus_cmd_e          snp_cmd,
    input  logic [TAG_W-1:0]  snp_tag,
    input  line_st_e          line_st,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              share,
    output logic              interv,
    output logic [DATA_W-1:0] interv_data,
    output logic              upd_en,
    output line_st_e          upd_st
);
    logic hit;
    assign hit = (line_st != LN_I) && (line_tag == snp_tag);

    always_comb begin
        share  = 1'b0;
        interv = 1'b0;
        upd_en = 1'b0;
        upd_st = line_st;
        case (snp_cmd)
            CMD_RD: begin
                share  = hit;
                interv = hit && (line_st == LN_M);
                upd_en = hit && (line_st != LN_S);
                upd_st = LN_S;
            end
            CMD_RDX: begin
                interv = hit && (line_st == LN_M);
                upd_en = hit;
                upd_st = LN_I;
            end
            CMD_UPG: begin
                upd_en = hit;
                upd_st = LN_I;
            end
            default: ;
        endcase
        interv_data = interv ? line_data : '0;
    end
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [2:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_share_i,
    input  logic [DATA_W-1:0] bus_fill_data,
    input  logic [2:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              share_o,
    output logic              inter_o,
    output logic [DATA_W-1:0] inter_data
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam int SETS  = 1 << IDX_W;

    ctl_t ctl_d, ctl_q;

    logic [IDX_W-1:0] c_idx, s_idx;
    logic [TAG_W-1:0] c_tag, s_tag;
    assign c_idx = cpu_addr[IDX_W-1:0];
    assign c_tag = cpu_addr[ADDR_W-1:IDX_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[ADDR_W-1:IDX_W];

    bus_cmd_e snp_e, cmd_e;
    assign snp_e   = bus_cmd_e'(snp_cmd);
    assign bus_cmd = cmd_e;

    line_st_e          lk_st, sn_st, upd_st, wl_st;
    logic [TAG_W-1:0]  lk_tag, sn_tag;
    logic [DATA_W-1:0] lk_data, sn_data, wl_data;
    logic              upd_en, wl_en, wl_data_en;
    line_st_e          st_all [SETS];

    mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_idx(c_idx), .lk_st(lk_st), .lk_tag(lk_tag), .lk_data(lk_data),
        .sn_idx(s_idx), .sn_st(sn_st), .sn_tag(sn_tag), .sn_data(sn_data),
        .wl_en(wl_en), .wl_idx(c_idx), .wl_st(wl_st), .wl_tag(c_tag),
        .wl_data_en(wl_data_en), .wl_data(wl_data),
        .ws_en(upd_en), .ws_idx(s_idx), .ws_st(upd_st),
        .st_all(st_all)
    );

    mesi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
        .snp_cmd(snp_e), .snp_tag(s_tag),
        .line_st(sn_st), .line_tag(sn_tag), .line_data(sn_data),
        .share(share_o), .interv(inter_o), .interv_data(inter_data),
        .upd_en(upd_en), .upd_st(upd_st)
    );

    logic hit, snp_clash;
    assign hit       = (lk_st != LN_I) && (lk_tag == c_tag);
    assign snp_clash = (snp_e != CMD_NONE) && (s_idx == c_idx);

    always_comb begin
        ctl_d      = ctl_q;
        cpu_done   = 1'b0;
        cpu_rdata  = '0;
        bus_req    = 1'b0;
        cmd_e      = CMD_NONE;
        bus_addr   = '0;
        bus_wdata  = '0;
        wl_en      = 1'b0;
        wl_st      = lk_st;
        wl_data_en = 1'b0;
        wl_data    = cpu_wdata;
        case (ctl_q.fsm)
            FSM_IDLE: begin
                if (cpu_req && !snp_clash) begin
                    if (hit && !cpu_we) begin
                        cpu_done  = 1'b1;
                        cpu_rdata = lk_data;
                    end else if (hit && (lk_st == LN_E || lk_st == LN_M)) begin
                        cpu_done   = 1'b1;
                        wl_en      = 1'b1;
                        wl_st      = LN_M;
                        wl_data_en = 1'b1;
                    end else if (!hit && lk_st == LN_M) begin
                        ctl_d.fsm = FSM_EVICT;
                    end else begin
                        ctl_d.fsm = FSM_FETCH;
                    end
                end
            end
            FSM_EVICT: begin
                if (lk_st == LN_M && lk_tag != c_tag) begin
                    bus_req = 1'b1;
                    if (bus_gnt) begin
                        cmd_e     = CMD_WB;
                        bus_addr  = {lk_tag, c_idx};
                        bus_wdata = lk_data;
                        wl_en     = 1'b1;
                        wl_st     = LN_I;
                        ctl_d.fsm = FSM_FETCH;
                    end
                end else begin
                    // victim lost ownership to a snoop while waiting
                    ctl_d.fsm = FSM_FETCH;
                end
            end
            FSM_FETCH: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    bus_addr   = cpu_addr;
                    cpu_done   = 1'b1;
                    wl_en      = 1'b1;
                    wl_data_en = 1'b1;
                    ctl_d.fsm  = FSM_IDLE;
                    if (cpu_we) begin
                        cmd_e = hit ? CMD_UPG : CMD_RDX;
                        wl_st = LN_M;
                    end else begin
                        cmd_e     = CMD_RD;
                        wl_st     = bus_share_i ? LN_S : LN_E;
                        wl_data   = bus_fill_data;
                        cpu_rdata = bus_fill_data;
                    end
                end
            end
            default: ctl_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q.fsm <= FSM_IDLE;
        else        ctl_q <= ctl_d;
    end

    // indices of the previous cycle, kept for the checks below
    logic [IDX_W-1:0] c_idx_q, s_idx_q;
    always_ff @(posedge clk) begin
        c_idx_q <= c_idx;
        s_idx_q <= s_idx;
    end

    p_fill_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_RD && !bus_share_i) |=> st_all[c_idx_q] == LN_E);
    p_fill_shared_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_RD && bus_share_i) |=> st_all[c_idx_q] == LN_S);
    p_upgrade_owns_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e == CMD_UPG) |=> st_all[c_idx_q] == LN_M);
    p_write_done_mod_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_done && cpu_we) |=> st_all[c_idx_q] == LN_M);
    p_share_only_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        share_o |-> snp_e == CMD_RD);
    p_interv_gives_up_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inter_o |=> st_all[s_idx_q] != LN_M);
    p_invalidate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((snp_e == CMD_RDX || snp_e == CMD_UPG) && sn_st != LN_I && sn_tag == s_tag)
        |=> st_all[s_idx_q] == LN_I);
    p_cmd_granted_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_e != CMD_NONE) |-> bus_gnt);
endmodule

// File: tb/test_mesi_snoop_ctrl.sv
`timescale 1ns/1ps
module test_mesi_snoop_ctrl;
    logic clk = 1'b0;
    always #4 clk = ~clk;
    logic rst_n;

    logic       creq [2];
    logic       cwe  [2];
    logic [7:0] caddr[2];
    logic [7:0] cwd  [2];
    logic       cdone[2];
    logic [7:0] crd  [2];
    logic       breq [2];
    logic       gnt  [2];
    logic [2:0] cmd  [2];
    logic [7:0] baddr[2];
    logic [7:0] bwd  [2];
    logic       shr  [2];
    logic       itv  [2];
    logic [7:0] idat [2];
    logic [7:0] fill [2];
    logic [7:0] mem  [256];
    logic       turn;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always_comb begin
        gnt[0]  = breq[0] && (!breq[1] || !turn);
        gnt[1]  = breq[1] && !gnt[0];
        fill[0] = itv[1] ? idat[1] : mem[baddr[0]];
        fill[1] = itv[0] ? idat[0] : mem[baddr[1]];
    end

    generate
        for (genvar k = 0; k < 2; k++) begin : g_cache
            mesi_snoop_ctrl i_mesi_snoop_ctrl (
                .clk(clk), .rst_n(rst_n),
                .cpu_req(creq[k]), .cpu_we(cwe[k]), .cpu_addr(caddr[k]),
                .cpu_wdata(cwd[k]), .cpu_done(cdone[k]), .cpu_rdata(crd[k]),
                .bus_req(breq[k]), .bus_gnt(gnt[k]), .bus_cmd(cmd[k]),
                .bus_addr(baddr[k]), .bus_wdata(bwd[k]),
                .bus_share_i(shr[1-k]), .bus_fill_data(fill[k]),
                .snp_cmd(cmd[1-k]), .snp_addr(baddr[1-k]),
                .share_o(shr[k]), .inter_o(itv[k]), .inter_data(idat[k])
            );
        end
    endgenerate

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
            turn <= 1'b0;
        end else begin
            for (int k = 0; k < 2; k++) begin
                if (cmd[k] == 3'd4) mem[baddr[k]] <= bwd[k];
                if (itv[k]) mem[baddr[1-k]] <= idat[k];
            end
            if (gnt[0]) turn <= 1'b1;
            else if (gnt[1]) turn <= 1'b0;
        end
    end

    // behavioural model: state 0=I 1=S 2=E 3=M per cache per index
    int mst [2][4];
    int mtag[2][4];
    int gval[256];

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R11 watchdog expired: actual=%0d cycles expected<=150000", cyc);
            summary();
        end
    end

    // R11 exclusivity of the model, checked every clock
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 4; i++) begin
                if (mst[0][i] != 0 && mst[1][i] != 0 && mtag[0][i] == mtag[1][i]
                    && (mst[0][i] >= 2 || mst[1][i] >= 2)) begin
                    bad++;
                    $display("FAIL R11 two owners idx %0d: actual=%0d/%0d expected=one owner",
                             i, mst[0][i], mst[1][i]);
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_op(int c, bit we, logic [7:0] a, logic [7:0] d, string req);
        int o = 1 - c;
        int idx = int'(a[1:0]);
        int tg  = int'(a[7:2]);
        int ecmd[4];
        int ne = 0;
        int obs[4];
        int nob = 0;
        bit eshare = 0, einter = 0, oshare = 0, ointer = 0;
        bit hit, ohit, seen = 0;
        int erd, ord = -1, w = 0;
        hit  = mst[c][idx] != 0 && mtag[c][idx] == tg;
        ohit = mst[o][idx] != 0 && mtag[o][idx] == tg;
        if (!we) begin
            if (!hit) begin
                if (mst[c][idx] == 3) begin ecmd[ne] = 4; ne++; end
                ecmd[ne] = 1; ne++;
                eshare = ohit;
                einter = ohit && mst[o][idx] == 3;
                if (ohit) mst[o][idx] = 1;
                mst[c][idx]  = ohit ? 1 : 2;
                mtag[c][idx] = tg;
            end
            erd = gval[a];
        end else begin
            erd = -1;
            if (hit && mst[c][idx] == 1) begin
                ecmd[ne] = 3; ne++;
            end else if (!hit) begin
                if (mst[c][idx] == 3) begin ecmd[ne] = 4; ne++; end
                ecmd[ne] = 2; ne++;
                einter = ohit && mst[o][idx] == 3;
            end
            if (ohit) mst[o][idx] = 0;
            mst[c][idx]  = 3;
            mtag[c][idx] = tg;
            gval[a] = int'(d);
        end

        @(negedge clk);
        creq[c] = 1'b1; cwe[c] = we; caddr[c] = a; cwd[c] = d;
        forever begin
            #1;
            if (cmd[c] != 3'd0) begin
                if (nob < 4) obs[nob] = int'(cmd[c]);
                nob++;
                if (cmd[c] == 3'd1) oshare = shr[o];
                if (cmd[c] == 3'd1 || cmd[c] == 3'd2) ointer = itv[o];
            end
            if (cdone[c]) begin seen = 1; ord = int'(crd[c]); end
            @(negedge clk);
            if (seen) begin creq[c] = 1'b0; break; end
            w++;
            if (w > 60) begin
                creq[c] = 1'b0;
                chk(0, {req, " request hung"}, w, 0);
                break;
            end
        end
        @(negedge clk);

        chk(nob == ne, {req, " command count"}, nob, ne);
        for (int i = 0; i < ne && i < nob; i++)
            chk(obs[i] == ecmd[i], {req, " command code"}, obs[i], ecmd[i]);
        if (!we) chk(ord == erd, {req, " read data (R11)"}, ord, erd);
        if (ne > 0 && ecmd[ne-1] == 1) chk(oshare == eshare, {req, " share (R6/R5)"}, int'(oshare), int'(eshare));
        if (ne > 0 && ecmd[ne-1] != 3) chk(ointer == einter, {req, " intervention (R7/R9)"}, int'(ointer), int'(einter));
    endtask

    initial begin
        int s = 7;
        for (int k = 0; k < 2; k++) begin
            creq[k] = 0; cwe[k] = 0; caddr[k] = 0; cwd[k] = 0;
            for (int i = 0; i < 4; i++) begin mst[k][i] = 0; mtag[k][i] = 0; end
        end
        for (int i = 0; i < 256; i++) gval[i] = int'(8'(i) ^ 8'h5A);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        for (int k = 0; k < 2; k++) begin
            chk(!breq[k] && cmd[k] == 3'd0 && !cdone[k], "R2 reset idle bus", int'(cmd[k]), 0);
            chk(!shr[k] && !itv[k], "R6 reset share/intervention low", int'(shr[k]), 0);
        end

        do_op(0, 0, 8'h10, 8'h00, "R2 read miss fill E (R5)");
        do_op(0, 1, 8'h10, 8'hA1, "R4 silent write on E");
        do_op(1, 0, 8'h10, 8'h00, "R7 intervention from M");
        do_op(1, 1, 8'h10, 8'hB2, "R3 upgrade on S, R9 peer invalidated");
        do_op(0, 0, 8'h10, 8'h00, "R7 second intervention, R5 fill S");
        do_op(0, 0, 8'h10, 8'h00, "R1 read hit no bus");
        do_op(0, 1, 8'h20, 8'hC3, "R10 clean victim dropped, R2 write miss");
        do_op(0, 1, 8'h30, 8'hD4, "R10 dirty victim writeback");
        do_op(1, 0, 8'h20, 8'h00, "R10 memory holds written-back data");
        do_op(0, 0, 8'h20, 8'h00, "R8 peer E goes S, R10 writeback");
        do_op(0, 1, 8'h20, 8'hE5, "R3 upgrade after shared fill (R5)");
        do_op(1, 1, 8'h05, 8'h11, "R2 read-for-ownership miss");
        do_op(0, 1, 8'h05, 8'h22, "R9 read-for-ownership hits peer M");
        do_op(1, 0, 8'h06, 8'h00, "R5 lone fill E");
        do_op(0, 1, 8'h06, 8'h33, "R9 peer E invalidated");
        do_op(1, 0, 8'h06, 8'h00, "R6 share and R7 data from M");
        do_op(1, 1, 8'h06, 8'h44, "R3 upgrade from S");

        for (int n = 0; n < 300; n++) begin
            int c, we, a, d;
            s = s * 1103515245 + 12345;
            c  = (s >>> 16) & 1;
            we = (s >>> 17) & 1;
            a  = (((s >>> 18) % 3) << 2) | ((s >>> 21) & 3);
            d  = (s >>> 8) & 255;
            do_op(c, bit'(we), 8'(a), 8'(d), "R11 mixed traffic");
        end

        summary();
    end
endmodule